// File: doc/BRIEF.md
# Staggered-PRI Chirp Scheduler

This block is the timing sequencer for a radar transmitter. It runs on its own without a trigger. A frame contains up to three sub-frames, one for each waveform class: short, medium and long. Each sub-frame has sixteen chirps. Every chirp has a transmit window and then a receive window, and each window lasts a number of clock cycles that the host programs. Each class has its own pair of lengths. Because the three pulse-repetition intervals differ, a later Doppler stage can resolve velocity aliases by comparing the intervals.

The host supplies six length values and a three-bit sub-frame enable mask. The block copies all of these at the start of each frame, so a frame never mixes old and new settings. For every chirp, the outputs give a transmit strobe, a receive strobe, the waveform class, the sub-frame tag and the chirp number, plus a one-cycle pulse at the start of each frame. With the suggested lengths at a 100 MHz clock, the three intervals are 175 µs, 161 µs and 167 µs:

| Class | Chirp length | Listen length |
|---|---|---|
| Short | 100 | 17400 |
| Medium | 500 | 15600 |
| Long | 3000 | 13700 |

Top module: `pri_ladder_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state is idle. In idle, both strobes and `frame_start` are 0, and `wave_sel`, `subframe_id` and `chirp_idx` are 0.
- R2: `wave_sel` encodes the class as 2'b00 short, 2'b01 medium and 2'b10 long. The code 2'b11 is never output. `subframe_id` carries the same code as `wave_sel` for every chirp.
- R3: Each chirp drives `chirp_active` for exactly its class's chirp length in cycles. `listen_active` follows immediately for exactly the listen length. The two strobes are never high together.
- R4: Each sub-frame has 16 chirps, with `chirp_idx` counting 0 to 15. Enabled sub-frames run in the order short, medium, long, and a new sub-frame begins the cycle after the previous one's last listen cycle ends.
- R5: The mask `sf_enable` uses bit 0 for short, bit 1 for medium and bit 2 for long. When a bit is cleared, that sub-frame is skipped entirely.
- R6: `frame_start` is high for one cycle, which is the first chirp cycle of each frame (index 0 of the first enabled sub-frame). If the mask is nonzero, the next frame begins the cycle after the last listen cycle of the previous frame.
- R7: The lengths and the mask are copied only at frame start. Changing them mid-frame has no effect until the next frame.
- R8: If the mask is all zeros when a frame would start, the block idles with no strobes. It starts a frame in the cycle after the first edge that sees a nonzero mask.
- R9: A chirp or listen length of 0 gives a one-cycle window.
- R10: A synchronous reset in the middle of a frame returns the block to idle at the short sub-frame, index 0. A frame then restarts once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| short_chirp_len | input | CNT_W | Short transmit window, cycles |
| med_chirp_len | input | CNT_W | Medium transmit window, cycles |
| long_chirp_len | input | CNT_W | Long transmit window, cycles |
| short_listen_len | input | CNT_W | Short receive window, cycles |
| med_listen_len | input | CNT_W | Medium receive window, cycles |
| long_listen_len | input | CNT_W | Long receive window, cycles |
| sf_enable | input | 3 | Sub-frame enable mask |
| chirp_active | output | 1 | Transmit window strobe |
| listen_active | output | 1 | Receive window strobe |
| wave_sel | output | 2 | Waveform class |
| subframe_id | output | 2 | Sub-frame tag |
| chirp_idx | output | IDX_W | Chirp number within the sub-frame |
| frame_start | output | 1 | First cycle of a frame |

## Verification
The hardest case to reach is a frame boundary where the settings change. The block then has to finish the old frame with its latched lengths and mask, and go straight into a new frame that uses the new lengths and mask. The stimulus changes the lengths and the mask partway through a frame, sets every length to zero, and clears the mask so that the block drains into idle. Short length values keep each frame to a few hundred cycles, so many frame boundaries occur. A behavioural model predicts every output on every clock.

// File: rtl/pri_ladder_sequencer.sv
module pri_ladder_sequencer #(
  parameter int CNT_W = 16,
  parameter int CHIRPS_PER_SF = 16,
  parameter int IDX_W = $clog2(CHIRPS_PER_SF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] short_chirp_len,
  input  logic [CNT_W-1:0] med_chirp_len,
  input  logic [CNT_W-1:0] long_chirp_len,
  input  logic [CNT_W-1:0] short_listen_len,
  input  logic [CNT_W-1:0] med_listen_len,
  input  logic [CNT_W-1:0] long_listen_len,
  input  logic [2:0]       sf_enable,
  output logic             chirp_active,
  output logic             listen_active,
  output logic [1:0]       wave_sel,
  output logic [1:0]       subframe_id,
  output logic [IDX_W-1:0] chirp_idx,
  output logic             frame_start
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHIRPS_PER_SF - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_CHIRP, PH_LISTEN} phase_t;

  phase_t           phase;
  logic [1:0]       sf;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] chirp_q  [3];
  logic [CNT_W-1:0] listen_q [3];
  logic [2:0]       mask_q;
  logic             fs_q;

  logic [CNT_W-1:0] cur_len;
  logic             seg_end, last_chirp, nxt_valid, frame_done, start;
  logic [1:0]       nxt_sf, first_sf;

  assign cur_len    = (phase == PH_CHIRP) ? chirp_q[sf] : listen_q[sf];
  assign seg_end    = ({1'b0, cnt} + 1'b1) >= {1'b0, cur_len};
  assign last_chirp = idx == LAST_IDX;
  assign first_sf   = sf_enable[0] ? 2'd0 : (sf_enable[1] ? 2'd1 : 2'd2);
  assign frame_done = phase == PH_LISTEN && seg_end && last_chirp && !nxt_valid;
  assign start      = (phase == PH_IDLE || frame_done) && |sf_enable;

  always_comb begin
    nxt_valid = 1'b0;
    nxt_sf    = sf;
    for (int s = 2; s >= 0; s--) begin
      if (2'(s) > sf && mask_q[s]) begin
        nxt_valid = 1'b1;
        nxt_sf    = 2'(s);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      sf     <= '0;
      idx    <= '0;
      cnt    <= '0;
      mask_q <= '0;
      fs_q   <= 1'b0;
      for (int i = 0; i < 3; i++) begin
        chirp_q[i]  <= '0;
        listen_q[i] <= '0;
      end
    end else begin
      fs_q <= start;
      if (start) begin
        chirp_q[0]  <= short_chirp_len;
        chirp_q[1]  <= med_chirp_len;
        chirp_q[2]  <= long_chirp_len;
        listen_q[0] <= short_listen_len;
        listen_q[1] <= med_listen_len;
        listen_q[2] <= long_listen_len;
        mask_q      <= sf_enable;
        sf          <= first_sf;
        idx         <= '0;
        cnt         <= '0;
        phase       <= PH_CHIRP;
      end else begin
        case (phase)
          PH_CHIRP: begin
            if (seg_end) begin
              phase <= PH_LISTEN;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          PH_LISTEN: begin
            if (seg_end) begin
              cnt <= '0;
              if (!last_chirp) begin
                idx   <= idx + 1'b1;
                phase <= PH_CHIRP;
              end else if (nxt_valid) begin
                sf    <= nxt_sf;
                idx   <= '0;
                phase <= PH_CHIRP;
              end else begin
                sf    <= '0;
                idx   <= '0;
                phase <= PH_IDLE;
              end
            end else cnt <= cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign chirp_active  = phase == PH_CHIRP;
  assign listen_active = phase == PH_LISTEN;
  assign wave_sel      = sf;
  assign subframe_id   = sf;
  assign chirp_idx     = idx;
  assign frame_start   = fs_q;

  assert_no_reserved_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wave_sel != 2'b11);

  assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(chirp_active && listen_active));

  assert_chirp_tag_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chirp_active |=> listen_active || (chirp_active && $stable(chirp_idx) && $stable(subframe_id)));

  assert_mask_honoured_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chirp_active |-> mask_q[sf]);

  assert_fs_on_first_chirp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> chirp_active && chirp_idx == '0);

  assert_idle_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!chirp_active && !listen_active && sf_enable == 3'b000) |=> (!chirp_active && !listen_active));

  assert_min_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chirp_active && chirp_q[sf] <= 1) |=> !chirp_active);

endmodule

// File: tb/pri_ladder_sequencer_tb_top.sv
module pri_ladder_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int NCH = 16;
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0;
  logic rst_n;
  logic [CNT_W-1:0] sc, mc, lc, sl, ml, ll;
  logic [2:0] en;
  logic ca, la, fs;
  logic [1:0] ws, sid;
  logic [3:0] cidx;

  always #(CLK_PERIOD/2) clk = ~clk;

  pri_ladder_sequencer dut_i (
    .clk(clk), .rst_n(rst_n),
    .short_chirp_len(sc), .med_chirp_len(mc), .long_chirp_len(lc),
    .short_listen_len(sl), .med_listen_len(ml), .long_listen_len(ll),
    .sf_enable(en),
    .chirp_active(ca), .listen_active(la), .wave_sel(ws),
    .subframe_id(sid), .chirp_idx(cidx), .frame_start(fs)
  );

  int vectors = 0, miscompares = 0, cycles = 0;
  string cur_req = "R1";

  int m_phase = 0, m_sf = 0, m_idx = 0, m_rem = 0, m_fs = 0, m_mask = 0;
  int m_ch[3], m_li[3];

  function automatic int eff(int x);
    return (x == 0) ? 1 : x;
  endfunction

  task automatic model_start();
    m_ch[0] = sc; m_ch[1] = mc; m_ch[2] = lc;
    m_li[0] = sl; m_li[1] = ml; m_li[2] = ll;
    m_mask = en;
    m_sf = en[0] ? 0 : (en[1] ? 1 : 2);
    m_idx = 0; m_phase = 1; m_rem = eff(m_ch[m_sf]); m_fs = 1;
  endtask

  task automatic model_step();
    if (!rst_n) begin
      m_phase = 0; m_sf = 0; m_idx = 0; m_fs = 0;
    end else if (m_phase == 0) begin
      m_fs = 0;
      if (en != 0) model_start();
    end else begin
      m_fs = 0;
      m_rem--;
      if (m_rem == 0) begin
        if (m_phase == 1) begin
          m_phase = 2; m_rem = eff(m_li[m_sf]);
        end else if (m_idx < NCH - 1) begin
          m_idx++; m_phase = 1; m_rem = eff(m_ch[m_sf]);
        end else begin
          int nxt = -1;
          for (int s = m_sf + 1; s < 3; s++)
            if (nxt < 0 && m_mask[s]) nxt = s;
          if (nxt >= 0) begin
            m_sf = nxt; m_idx = 0; m_phase = 1; m_rem = eff(m_ch[m_sf]);
          end else if (en != 0) model_start();
          else begin
            m_phase = 0; m_sf = 0; m_idx = 0;
          end
        end
      end
    end
  endtask

  task automatic compare();
    logic e_ca, e_la;
    e_ca = (m_phase == 1);
    e_la = (m_phase == 2);
    vectors++;
    if (ca !== e_ca || la !== e_la) begin
      miscompares++;
      $display("FAIL %s/R3 strobes chirp,listen=%b%b expected %b%b at cycle %0d", cur_req, ca, la, e_ca, e_la, cycles);
    end else if (ws !== 2'(m_sf) || sid !== 2'(m_sf)) begin
      miscompares++;
      $display("FAIL %s/R2 sel=%0d id=%0d expected %0d at cycle %0d", cur_req, ws, sid, m_sf, cycles);
    end else if (cidx !== 4'(m_idx)) begin
      miscompares++;
      $display("FAIL %s/R4 chirp_idx=%0d expected %0d at cycle %0d", cur_req, cidx, m_idx, cycles);
    end else if (fs !== 1'(m_fs)) begin
      miscompares++;
      $display("FAIL %s/R6 frame_start=%b expected %0d at cycle %0d", cur_req, fs, m_fs, cycles);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      model_step();
      @(negedge clk);
      cycles++;
      compare();
    end
  endtask

  task automatic set_lens(int a, int b, int c, int d, int e, int f);
    sc = CNT_W'(a); sl = CNT_W'(b); mc = CNT_W'(c); ml = CNT_W'(d); lc = CNT_W'(e); ll = CNT_W'(f);
  endtask

  initial begin
    rst_n = 1'b0; en = 3'b111;
    set_lens(3, 10, 5, 6, 7, 8);
    cur_req = "R1"; tick(3);
    rst_n = 1'b1;
    cur_req = "R2 R3 R4 R6"; tick(1300);
    cur_req = "R5"; en = 3'b101; tick(1300);
    en = 3'b010; tick(800);
    en = 3'b100; tick(800);
    en = 3'b110; tick(1200);
    cur_req = "R7"; en = 3'b111; tick(300);
    set_lens(2, 4, 1, 9, 6, 3); en = 3'b011; tick(1500);
    cur_req = "R9"; en = 3'b111; set_lens(0, 0, 0, 0, 0, 0); tick(400);
    set_lens(0, 2, 3, 0, 0, 1); tick(400);
    cur_req = "R8"; en = 3'b000; tick(700);
    en = 3'b001; set_lens(2, 3, 2, 3, 2, 3); tick(300);
    cur_req = "R10"; tick(37); rst_n = 1'b0; tick(3);
    rst_n = 1'b1; en = 3'b111; tick(600);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired at cycle %0d expected completion", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule